// File: doc/BRIEF.md
# Pipelined Array Add-and-Scale Engine

This block is a fixed streaming kernel. It walks two source arrays and one destination array of equal length and writes, for every index i, the value C[i] = (A[i] + B[i]) / 4. An internal index counter generates addresses. The same index addresses both read-only source memories at once. The arithmetic is split by registers into pipeline stages. A new element enters the pipe on every clock, and once the pipe is full one result leaves on every clock.

A single start pulse launches a run over all elements. The sources are synchronous memories with a read latency of one cycle. Each result carries its own index through the pipe, so it lands at its own location in the destination memory. A one-cycle done pulse marks the end of the run. A parameter selects the stage count. With two stages, the sum and the divide each take one stage. With four stages, the adder is split into a low half and a high half, followed by the divide and an output stage. Both forms give the same results; the four-stage form takes two more cycles to fill.

Top module: `add_scale_engine`

## Requirements
- R1: While reset is held, and in the idle cycles after it is released, `src_rd_en`, `c_wr_en` and `done` are all low.
- R2: A start sampled high while idle makes `src_rd_en` high for exactly N_ELEM (default 100) consecutive cycles, starting in the cycle after that edge, with `src_addr` counting 0, 1, … N_ELEM-1.
- R3: The engine expects `a_rdata` and `b_rdata` to hold the words addressed by `src_addr` in the cycle after `src_rd_en` was high, and uses them in that cycle.
- R4: Each written word is the 17-bit unsigned sum of the two 16-bit source words shifted right by two, which truncates toward zero. Its top bit is always 0; for example, two all-ones words give 0x7FFF.
- R5: Results are written with `c_wr_en` high on N_ELEM consecutive cycles, one per cycle. `c_addr` ascends from 0 to N_ELEM-1, and every word goes to the index of its own source pair.
- R6: Counting the edge that samples start as edge 0, the write of element 0 is presented after edge STAGES+1: edge 3 for two stages, edge 5 for four.
- R7: `done` is high for exactly one cycle, in the cycle after the write of element N_ELEM-1. That is after edge N_ELEM+1+STAGES (103 for two stages, 105 for four).
- R8: A start pulse while a run is in progress or the pipe is draining is ignored. The read stream is not restarted, and the run length and write count are unchanged.
- R9: With STAGES = 4 every written word and address equals the two-stage result; only the fill delay differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch a run when idle |
| done | output | 1 | One-cycle pulse after the last element is written |
| src_rd_en | output | 1 | Read strobe to both source memories |
| src_addr | output | ADDR_W | Shared source index |
| a_rdata | input | DATA_W | A word, one cycle after the read strobe |
| b_rdata | input | DATA_W | B word, one cycle after the read strobe |
| c_wr_en | output | 1 | Write strobe to the destination memory |
| c_addr | output | ADDR_W | Destination index |
| c_wdata | output | DATA_W | Destination word |

## Verification
All timing is counted from the edge that samples start. The read of index k is due after edge k. The write of index k is due after edge k+1+STAGES, and done is due after edge N_ELEM+1+STAGES. The bench drives a two-stage and a four-stage instance side by side. It samples both on the falling edge and keeps a per-cycle edge counter. Each observed write and pulse is compared with the edge on which it is due, and each written word is compared with a value computed from the source pattern.

// File: rtl/ase_pkg.sv
package ase_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ase_rst_sync.sv
module ase_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/ase_index_gen.sv
module ase_index_gen
  import ase_pkg::*;
#(
  parameter int N_ELEM = 100,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pipe_busy,
  output logic              issue,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_ELEM - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              idx_en;

  // next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start && !pipe_busy) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      SEQ_RUN: begin
        idx_en = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = SEQ_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign issue = (state_q == SEQ_RUN);
  assign idx   = idx_q;
endmodule

// File: rtl/ase_arith_pipe.sv
module ase_arith_pipe #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              any_valid
);
  localparam int SUM_W = DATA_W + 1;
  localparam int QUO_W = DATA_W - 1;
  localparam int LO_W  = DATA_W / 2;
  localparam int HI_W  = DATA_W - LO_W;

  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] st_en;
  logic [ADDR_W-1:0] tag_q [STAGES];

  assign st_en = {vld_q[STAGES-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= st_en;
  end

  // index tag travels beside the data of every stage
  for (genvar s = 0; s < STAGES; s++) begin : g_tag
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (st_en[0]) tag_q[0] <= in_addr;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (st_en[s]) tag_q[s] <= tag_q[s-1];
      end
    end
  end

  if (STAGES == 4) begin : g_four
    logic [LO_W:0]      lo_q;
    logic [HI_W-1:0]    ahi_q, bhi_q;
    logic [SUM_W-1:0]   sum_q;
    logic [QUO_W-1:0]   quo_q, out_q;
    logic               sum_lo_unused;

    always_ff @(posedge clk) begin
      if (st_en[0]) begin
        lo_q  <= {1'b0, in_a[LO_W-1:0]} + {1'b0, in_b[LO_W-1:0]};
        ahi_q <= in_a[DATA_W-1:LO_W];
        bhi_q <= in_b[DATA_W-1:LO_W];
      end
      if (st_en[1]) sum_q <= {({1'b0, ahi_q} + {1'b0, bhi_q} + {{HI_W{1'b0}}, lo_q[LO_W]}),
                              lo_q[LO_W-1:0]};
      if (st_en[2]) quo_q <= sum_q[SUM_W-1:2];
      if (st_en[3]) out_q <= quo_q;
    end

    assign sum_lo_unused = ^sum_q[1:0];
    assign out_data      = {1'b0, out_q};
  end else begin : g_two
    logic [SUM_W-1:0] sum_q;
    logic [QUO_W-1:0] quo_q;
    logic             sum_lo_unused;

    always_ff @(posedge clk) begin
      if (st_en[0]) sum_q <= {1'b0, in_a} + {1'b0, in_b};
      if (st_en[1]) quo_q <= sum_q[SUM_W-1:2];
    end

    assign sum_lo_unused = ^sum_q[1:0];
    assign out_data      = {1'b0, quo_q};
  end

  assign out_valid = vld_q[STAGES-1];
  assign out_addr  = tag_q[STAGES-1];
  assign any_valid = |vld_q;
endmodule

// File: rtl/add_scale_engine.sv
module add_scale_engine #(
  parameter int DATA_W = 16,
  parameter int N_ELEM = 100,
  parameter int STAGES = 2,
  parameter int ADDR_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] a_rdata,
  input  logic [DATA_W-1:0] b_rdata,
  output logic              c_wr_en,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_wdata
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_ELEM - 1);

  logic              rst_core_n;
  logic              issue;
  logic [ADDR_W-1:0] idx;
  logic              rd_v_q;
  logic [ADDR_W-1:0] rd_tag_q;
  logic              pipe_any;
  logic              pipe_busy;
  logic              done_d, done_q;

  ase_rst_sync #(.SYNC_STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ase_index_gen #(.N_ELEM(N_ELEM), .ADDR_W(ADDR_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .pipe_busy (pipe_busy),
    .issue     (issue),
    .idx       (idx)
  );

  // read-latency stage: tag matches the word the memories return
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_v_q <= 1'b0;
    else             rd_v_q <= issue;
  end

  always_ff @(posedge clk) begin
    if (issue) rd_tag_q <= idx;
  end

  ase_arith_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (rd_v_q),
    .in_addr   (rd_tag_q),
    .in_a      (a_rdata),
    .in_b      (b_rdata),
    .out_valid (c_wr_en),
    .out_addr  (c_addr),
    .out_data  (c_wdata),
    .any_valid (pipe_any)
  );

  assign pipe_busy = rd_v_q | pipe_any;
  assign done_d    = c_wr_en && (c_addr == LAST_IDX);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign done      = done_q;
  assign src_rd_en = issue;
  assign src_addr  = idx;
endmodule

// File: rtl/ase_engine_chk.sv
module ase_engine_chk #(
  parameter int DATA_W = 16,
  parameter int N_ELEM = 100,
  parameter int STAGES = 2,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              src_rd_en,
  input logic [ADDR_W-1:0] src_addr,
  input logic              c_wr_en,
  input logic [ADDR_W-1:0] c_addr,
  input logic              c_wdata_msb
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_ELEM - 1);

  initial begin
    assert_stage_param_R9: assert (STAGES == 2 || STAGES == 4);
  end

  assert_rd_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en && src_addr != LAST_IDX |=> src_rd_en && src_addr == $past(src_addr) + 1'b1);

  assert_rd_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_rd_en) |-> src_addr == '0);

  assert_wr_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en && c_addr != LAST_IDX |=> c_wr_en && c_addr == $past(c_addr) + 1'b1);

  assert_wr_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_wr_en) |-> c_addr == '0);

  assert_word_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> !c_wdata_msb);

  assert_write_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> $past(src_rd_en, STAGES + 1) && c_addr == $past(src_addr, STAGES + 1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(c_wr_en) && $past(c_addr) == LAST_IDX);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && src_rd_en |=> !(src_rd_en && src_addr == '0));
endmodule

bind add_scale_engine ase_engine_chk #(
  .DATA_W(DATA_W), .N_ELEM(N_ELEM), .STAGES(STAGES), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .src_rd_en   (src_rd_en),
  .src_addr    (src_addr),
  .c_wr_en     (c_wr_en),
  .c_addr      (c_addr),
  .c_wdata_msb (c_wdata[DATA_W-1])
);

// File: tb/tb_add_scale_engine.sv
module tb_add_scale_engine;
  localparam int N  = 100;
  localparam int DW = 16;
  localparam int AW = 7;
  localparam int NV = 5;
  // {a_mul, a_add, b_mul, b_add}: A[i] = i*a_mul + a_add, B[i] = i*b_mul + b_add (mod 2^16)
  localparam logic [15:0] VEC [NV][4] = '{
    '{16'd1,    16'd0,     16'd1,     16'd0},
    '{16'd0,    16'hFFFF,  16'd0,     16'hFFFF},
    '{16'd0,    16'd0,     16'd0,     16'd0},
    '{16'd257,  16'd3,     16'h03A1,  16'h8000},
    '{16'd0,    16'd1,     16'd0,     16'd2}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start;
  logic          rd_en_w   [2];
  logic [AW-1:0] rd_addr_w [2];
  logic [DW-1:0] a_q [2], b_q [2];
  logic          wr_en_w   [2];
  logic [AW-1:0] wr_addr_w [2];
  logic [DW-1:0] wr_data_w [2];
  logic          done_w    [2];
  logic [15:0]   am, aa, bm, ba;
  int errors = 0;
  int checks = 0;

  function automatic logic [15:0] src_a(int i);
    return 16'(i * int'(am) + int'(aa));
  endfunction
  function automatic logic [15:0] src_b(int i);
    return 16'(i * int'(bm) + int'(ba));
  endfunction
  function automatic int exp_c(int i);
    logic [16:0] s;
    s = {1'b0, src_a(i)} + {1'b0, src_b(i)};
    return int'(s >> 2);
  endfunction

  for (genvar g = 0; g < 2; g++) begin : lane
    localparam int STG = (g == 0) ? 2 : 4;
    add_scale_engine #(.DATA_W(DW), .N_ELEM(N), .STAGES(STG)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done_w[g]),
      .src_rd_en(rd_en_w[g]), .src_addr(rd_addr_w[g]),
      .a_rdata(a_q[g]), .b_rdata(b_q[g]),
      .c_wr_en(wr_en_w[g]), .c_addr(wr_addr_w[g]), .c_wdata(wr_data_w[g])
    );
    // source memories: one-cycle synchronous read (R3)
    always @(posedge clk) begin
      if (rd_en_w[g]) begin
        a_q[g] <= src_a(int'(rd_addr_w[g]));
        b_q[g] <= src_b(int'(rd_addr_w[g]));
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_run(bit glitch);
    int k;
    int first_k [2];
    int done_k  [2];
    int nexp    [2];
    int wcnt    [2];
    for (int g = 0; g < 2; g++) begin
      first_k[g] = -1; done_k[g] = -1; nexp[g] = 0; wcnt[g] = 0;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (k < 400) begin
      for (int g = 0; g < 2; g++) begin
        if (wr_en_w[g]) begin
          if (first_k[g] < 0) first_k[g] = k;
          chk(int'(wr_addr_w[g]) == nexp[g], "R5", "write address order",
              int'(wr_addr_w[g]), nexp[g]);
          chk(int'(wr_data_w[g]) == exp_c(int'(wr_addr_w[g])), (g == 0) ? "R3 R4" : "R9",
              "written word", int'(wr_data_w[g]), exp_c(int'(wr_addr_w[g])));
          nexp[g]++;
          wcnt[g]++;
        end
        if (done_w[g]) begin
          if (done_k[g] < 0) done_k[g] = k;
          else chk(1'b0, "R7", "done longer than one cycle", k, done_k[g]);
        end
      end
      if (k < N)
        chk(rd_en_w[0] && int'(rd_addr_w[0]) == k, "R2", "read index", int'(rd_addr_w[0]), k);
      else if (k < N + 8)
        chk(!rd_en_w[0], "R2", "read strobe after last index", int'(rd_en_w[0]), 0);
      if (done_k[0] >= 0 && done_k[1] >= 0 && k > done_k[0] && k > done_k[1]) break;
      start = glitch && (k == 30 || k == 101);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    if (k >= 400) chk(1'b0, "R7", "watchdog: run never finished", k, 0);
    for (int g = 0; g < 2; g++) begin
      chk(first_k[g] == ((g == 0) ? 3 : 5), "R6", "first write edge",
          first_k[g], (g == 0) ? 3 : 5);
      chk(done_k[g] == N + ((g == 0) ? 3 : 5), "R7", "done edge",
          done_k[g], N + ((g == 0) ? 3 : 5));
      chk(wcnt[g] == N, glitch ? "R8" : "R5", "write count", wcnt[g], N);
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: simulation did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    am = '0; aa = '0; bm = '0; ba = '0;
    repeat (3) @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk(!rd_en_w[g] && !wr_en_w[g] && !done_w[g], "R1", "outputs in reset", 1, 0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk(!rd_en_w[g] && !wr_en_w[g] && !done_w[g], "R1", "outputs idle after reset", 1, 0);
    end
    for (int v = 0; v < NV; v++) begin
      am = VEC[v][0]; aa = VEC[v][1]; bm = VEC[v][2]; ba = VEC[v][3];
      do_run(v == 3);   // v==3 also pulses start mid-run and while draining (R8)
      repeat (2) @(negedge clk);
    end
    // R4 corner: all-ones inputs give 0x7FFF
    am = VEC[1][0]; aa = VEC[1][1]; bm = VEC[1][2]; ba = VEC[1][3];
    chk(exp_c(N - 1) == 32'h7FFF, "R4", "all-ones reference", exp_c(N - 1), 32'h7FFF);
    // R8: idle after the pulses, nothing restarted
    for (int g = 0; g < 2; g++) begin
      chk(!rd_en_w[g] && !wr_en_w[g], "R8", "idle after ignored start", int'(rd_en_w[g]), 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule